// File: doc/BRIEF.md
# Windowed Register File

This block is a register file that a processor reaches through a 5-bit logical register number. A window pointer sits between the logical number and the storage. The physical location is the window number times a stride of 16, plus the logical number. Adjacent windows therefore share 16 registers: the upper half of one window is the lower half of the next. That shared half lets a caller pass values to a callee without copying them. With 8 windows the block holds 144 physical registers.

The window moves by one step on each rising edge of the step-up or step-down strobe. The system clock samples both strobes. A window-reset input returns the pointer to window 0 and leaves the stored values as they are. A sticky overflow flag reports any attempt to step above the last window or below window 0. Reads are combinational from the mapped location. A write lands on the clock edge at which the write strobe is high.

Top module: `wrf_regfile`

## Requirements
- R1: After rst_n is released, win_ovf is 0 and the window is 0, so logical register n reads physical register n.
- R2: rd_data shows, without a clock edge, the content of physical register window*16 + reg_addr.
- R3: A rising edge on win_up (a 0 in one cycle, then 1) moves the window up by one at the clock edge that first samples the 1. Holding win_up high for several cycles moves it only once.
- R4: A rising edge on win_down moves the window down by one in the same way.
- R5: A win_rst sampled high sets the window to 0 and clears win_ovf, and no stored register value changes. It takes precedence over both step strobes.
- R6: A step up from the last window (window 7 by default), or a step down from window 0, leaves the window unchanged and sets win_ovf to 1.
- R7: Once set, win_ovf stays 1 through later legal steps until win_rst.
- R8: When rising edges on win_up and win_down are seen in the same cycle, neither takes effect: the window and win_ovf do not change.
- R9: With wr_en high at a clock edge, wr_data is stored at window*16 + reg_addr. With wr_en low, no register changes.
- R10: Logical registers 16 to 31 of window w are the same physical registers as logical registers 0 to 15 of window w+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of window, flag and edge detectors |
| reg_addr | input | 5 | Logical register number |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Data to write |
| rd_data | output | 16 | Content of the mapped register |
| win_up | input | 1 | Step-up strobe, acts on its rising edge |
| win_down | input | 1 | Step-down strobe, acts on its rising edge |
| win_rst | input | 1 | Synchronous window reset; contents are kept |
| win_ovf | output | 1 | Sticky window overflow flag |

## Verification
The assertions assume that all inputs are driven to known values at each clock edge. They also assume that a step strobe is a level that goes high for at least one sampled cycle and low for at least one before its next pulse, so that the edge detectors see each pulse exactly once. The bench changes every input on the falling clock edge and holds each strobe for whole cycles. It always lowers a strobe before raising it again. It reads the register file only at locations it has written first.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  // Physical index of a logical register inside a given window.
  function automatic int unsigned map_phys(input int unsigned win,
                                           input int unsigned laddr,
                                           input int unsigned stride);
    return win * stride + laddr;
  endfunction

  // Number of physical registers needed by a window set.
  function automatic int unsigned phys_count(input int unsigned nwin,
                                             input int unsigned stride,
                                             input int unsigned nlog);
    return (nwin - 1) * stride + nlog;
  endfunction
endpackage

// File: rtl/wrf_rise_det.sv
module wrf_rise_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev[i] <= 1'b0;
      else        prev[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev[i];

    AST_RISE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> !rise[i]);  // R3
  end
endmodule

// File: rtl/wrf_window_ctrl.sv
module wrf_window_ctrl #(
  parameter int NUM_WIN = 8,
  localparam int WW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_evt,
  input  logic          dn_evt,
  input  logic          win_rst,
  output logic [WW-1:0] win,
  output logic          ovf
);
  localparam logic [WW-1:0] TOP = WW'(NUM_WIN - 1);

  logic do_up, do_dn, hit_top, hit_bot;
  assign do_up   = up_evt & ~dn_evt;
  assign do_dn   = dn_evt & ~up_evt;
  assign hit_top = do_up & (win == TOP);
  assign hit_bot = do_dn & (win == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win <= '0;
      ovf <= 1'b0;
    end else if (win_rst) begin
      win <= '0;
      ovf <= 1'b0;
    end else begin
      if (hit_top || hit_bot) ovf <= 1'b1;
      else if (do_up)         win <= win + 1'b1;
      else if (do_dn)         win <= win - 1'b1;
    end
  end

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (up_evt && !dn_evt && !win_rst && win != TOP) |=> win == $past(win) + 1'b1);  // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_evt && !up_evt && !win_rst && win != '0) |=> win == $past(win) - 1'b1);  // R4
  AST_WIN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    win_rst |=> (win == '0 && !ovf));  // R5
  AST_PIN_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_rst && (hit_top || hit_bot)) |=> ($stable(win) && ovf));  // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !win_rst) |=> ovf);  // R7
  AST_BOTH_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (up_evt && dn_evt && !win_rst) |=> ($stable(win) && $stable(ovf)));  // R8
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
  parameter int NPHYS = 144,
  parameter int DW    = 16,
  localparam int PW   = $clog2(NPHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] paddr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] regs [NPHYS];

  // Contents carry no reset: window resets must keep them.
  always_ff @(posedge clk) begin
    if (we) regs[paddr] <= wdata;
  end

  assign rdata = regs[paddr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs[$past(paddr)] == $past(wdata));  // R9
endmodule

// File: rtl/wrf_regfile.sv
module wrf_regfile #(
  parameter int DW      = 16,
  parameter int LAW     = 5,
  parameter int NUM_WIN = 8,
  parameter int STRIDE  = 16,
  localparam int NLOG   = 1 << LAW,
  localparam int NPHYS  = wrf_pkg::phys_count(NUM_WIN, STRIDE, NLOG),
  localparam int PW     = $clog2(NPHYS),
  localparam int WW     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [LAW-1:0] reg_addr,
  input  logic           wr_en,
  input  logic [DW-1:0]  wr_data,
  output logic [DW-1:0]  rd_data,
  input  logic           win_up,
  input  logic           win_down,
  input  logic           win_rst,
  output logic           win_ovf
);
  logic [1:0]    step_rise;
  logic [WW-1:0] win;
  logic [PW-1:0] paddr;

  wrf_rise_det #(.N(2)) u_edges (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({win_down, win_up}),
    .rise (step_rise)
  );

  wrf_window_ctrl #(.NUM_WIN(NUM_WIN)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .up_evt (step_rise[0]),
    .dn_evt (step_rise[1]),
    .win_rst(win_rst),
    .win    (win),
    .ovf    (win_ovf)
  );

  assign paddr = PW'(wrf_pkg::map_phys(int'(win), int'(reg_addr), STRIDE));

  wrf_storage #(.NPHYS(NPHYS), .DW(DW)) u_mem (
    .clk  (clk),
    .rst_n(rst_n),
    .paddr(paddr),
    .we   (wr_en),
    .wdata(wr_data),
    .rdata(rd_data)
  );

  AST_MAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(paddr) < NPHYS);  // R2
  AST_RESET_STATE: assert property (@(posedge clk)
    $rose(rst_n) |-> (win == '0 && !win_ovf));  // R1
endmodule

// File: tb/wrf_regfile_test.sv
module wrf_regfile_test;
  localparam int NWIN = 8;
  localparam int NPH  = 144;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        win_up = 1'b0, win_down = 1'b0, win_rst = 1'b0;
  logic        win_ovf;

  int vectors = 0, errors = 0;
  int m_win = 0;
  bit m_ovf = 1'b0;
  logic [15:0] m_mem [NPH];

  wrf_regfile uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .win_up(win_up),
    .win_down(win_down), .win_rst(win_rst), .win_ovf(win_ovf)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d, input bit en = 1'b1);
    @(negedge clk);
    reg_addr = 5'(a); wr_data = d; wr_en = en;
    if (en) m_mem[m_win * 16 + a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input int a);
    reg_addr = 5'(a);
    #1;
    check(req, rd_data, m_mem[m_win * 16 + a]);
  endtask

  task automatic check_window(input string req);
    for (int a = 0; a < 32; a++) rd_check(req, a);
    check({req, " ovf"}, {15'd0, win_ovf}, {15'd0, m_ovf});
  endtask

  // Model of one sampled cycle with the given edge events.
  task automatic model_step(input bit u, input bit d, input bit r);
    if (r) begin m_win = 0; m_ovf = 1'b0; end
    else if (u && !d) begin
      if (m_win == NWIN - 1) m_ovf = 1'b1; else m_win++;
    end else if (d && !u) begin
      if (m_win == 0) m_ovf = 1'b1; else m_win--;
    end
  endtask

  task automatic pulse(input bit u, input bit d, input bit r, input int hold = 1);
    @(negedge clk);
    win_up = u; win_down = d; win_rst = r;
    model_step(u, d, r);
    for (int i = 1; i < hold; i++) begin
      @(negedge clk);
      model_step(1'b0, 1'b0, r);
    end
    @(negedge clk);
    win_up = 1'b0; win_down = 1'b0; win_rst = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 ovf after reset", {15'd0, win_ovf}, 16'd0);
    wr(3, 16'h0C03);
    rd_check("R1 window 0 maps reg 3", 3);
  endtask

  task automatic t_fill;
    // Window by window; the model tracks overlapping overwrites.
    for (int w = 0; w < NWIN; w++) begin
      for (int a = 0; a < 32; a++) wr(a, 16'(16'hA000 + w * 256 + a));
      check_window("R2 R9 fill readback");
      if (w < NWIN - 1) pulse(1'b1, 1'b0, 1'b0);
    end
  endtask

  task automatic t_overlap;
    pulse(1'b0, 1'b0, 1'b1);
    pulse(1'b1, 1'b0, 1'b0);
    wr(20, 16'h5A5A);
    pulse(1'b1, 1'b0, 1'b0);
    reg_addr = 5'd4; #1;
    check("R10 overlap w1.r20 == w2.r4", rd_data, 16'h5A5A);
    pulse(1'b0, 1'b1, 1'b0);
    check_window("R4 step down");
  endtask

  task automatic t_held;
    pulse(1'b1, 1'b0, 1'b0, 4);
    check_window("R3 held level steps once");
  endtask

  task automatic t_top;
    pulse(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < NWIN - 1; i++) pulse(1'b1, 1'b0, 1'b0);
    check_window("R3 at last window");
    pulse(1'b1, 1'b0, 1'b0);
    check_window("R6 up past last window");
    pulse(1'b0, 1'b1, 1'b0);
    check_window("R7 ovf sticky after legal step");
    pulse(1'b0, 1'b0, 1'b1);
    check_window("R5 window reset keeps contents");
  endtask

  task automatic t_bottom;
    pulse(1'b0, 1'b1, 1'b0);
    check_window("R6 down below window 0");
    pulse(1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_both;
    pulse(1'b1, 1'b0, 1'b0);
    pulse(1'b1, 1'b1, 1'b0);
    check_window("R8 simultaneous edges cancel");
    pulse(1'b1, 1'b1, 1'b1);
    check_window("R5 reset beats steps");
  endtask

  task automatic t_no_write;
    wr(7, 16'hDEAD, 1'b0);
    rd_check("R9 no write without wr_en", 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_overlap();
    t_held();
    t_top();
    t_bottom();
    t_both();
    t_no_write();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    vectors++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule